// File: doc/BRIEF.md
# Interrupt Entry and Return Controller

This block sits beside a processor core and runs the entry and return sequence for a small set of maskable interrupt lines. It holds a pending register, an enable register, a global mask bit and a protected-register write-enable bit. When an enabled line is pending and the global mask is clear, the block takes the interrupt by itself, with no separate acknowledge from the core. It pushes the enable register and the mask onto an internal context stack. It then clears the serviced line's pending and enable bits, sets the mask, clears the write-enable bit, and emits the line index on a vector output with a one-cycle request pulse.

A return strobe pops the stack. The enable register and the mask get back their pre-entry values, so any change a handler made to the enable register is discarded. A handler can nest interrupts by rewriting the enable register and clearing the mask. Peripheral groups feed the low-numbered lines through a latch. After a group has fired, it stays blocked until software writes a one to that group's bit in the acknowledge register. Entry never clears that latch.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the pending, enable and group-blocked registers read zero, the control register reads 0x1 (mask set, write-enable clear, overflow clear), and no request is issued.
- R2: When several lines are pending and enabled and the mask is clear, the lowest-numbered line is taken. Its index appears on `irq_vec` while `irq_req` is high for exactly one cycle.
- R3: On entry the serviced line's pending bit clears without any software write.
- R4: On entry the serviced line's enable bit clears and the other enable bits are unchanged. The mask bit (control bit 0) sets and the write-enable bit (control bit 1) clears.
- R5: A return strobe reloads the enable register and the mask from the most recent stack frame, and overrides any enable value written inside the handler.
- R6: While the mask is set, no interrupt is taken. A nested entry happens only after the handler enables a line and writes 0 to control bit 0.
- R7: No interrupt is taken in a cycle with the return strobe high. Taking resumes in the next cycle, using the restored state.
- R8: Group g sets pending line g and becomes blocked. While blocked, further events of group g are ignored, and entry does not unblock it. Writing 1 to bit g at address 3 unblocks it. Reading address 3 returns the blocked flags.
- R9: The stack holds 4 frames. An entry with the stack full still takes the interrupt but drops the frame, and sets the sticky overflow flag (control bit 2), which only reset clears.
- R10: A return strobe with the stack empty changes nothing.
- R11: Register map: address 0 is pending (a written 1 sets a bit), address 1 is enable (read/write), address 2 is control (bits 0 and 1 writable, bit 2 read-only), address 3 is group blocked/acknowledge.
- R12: A line event that arrives in the cycle its line is taken leaves that line pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Per-line event, sets pending while high |
| grp_evt | input | NUM_GROUPS | Group event, sets line g unless group g is blocked |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| iret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | One-cycle pulse on interrupt entry |
| irq_vec | output | VEC_W | Index of the line being entered |

## Verification
The return strobe and the selection of a new interrupt can fall in the same cycle. The bench provokes this with two back-to-back return strobes. After the first one, the restored state has the mask clear and an enabled pending line. The second strobe has to hold that line off, and then expose the outer frame. The bench judges the result by requiring `irq_req` to be low in the cycle after the second strobe, with the outer enable value visible. The scoreboard then requires exactly one request for the lowest line that is eligible under the outer frame.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PEND = 2'd0,
        REG_ENAB = 2'd1,
        REG_CTRL = 2'd2,
        REG_GACK = 2'd3
    } reg_sel_e;

    localparam int CTRL_GMASK = 0;
    localparam int CTRL_PWE   = 1;
    localparam int CTRL_OVF   = 2;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_ENTER  = 2'd1,
        ACT_RETURN = 2'd2
    } ctx_act_e;

    function automatic ctx_act_e pick_action(input logic can_take,
                                             input logic ret_strobe,
                                             input logic stack_empty);
        if (ret_strobe)
            return stack_empty ? ACT_IDLE : ACT_RETURN;
        else if (can_take)
            return ACT_ENTER;
        else
            return ACT_IDLE;
    endfunction

endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int NUM_LINES = 8,
    localparam int VEC_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] elig,
    output logic                 found,
    output logic [VEC_W-1:0]     idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = VEC_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack #(
    parameter int FRAME_W = 9,
    parameter int DEPTH   = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic [FRAME_W-1:0] push_frame,
    input  logic               pop,
    output logic [FRAME_W-1:0] top_frame,
    output logic               empty,
    output logic               overflow
);

    logic [FRAME_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   top_idx;
    logic               full;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign top_idx = empty ? '0 : cnt_q - 1'b1;
    assign top_frame = mem[top_idx[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            overflow <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            if (full) begin
                overflow <= 1'b1;
            end else begin
                mem[cnt_q[IDX_W-1:0]] <= push_frame;
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R9

    AST_POP_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty); // R10

    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (rst)
        !(push && pop)); // R7

endmodule

// File: rtl/irq_grp_latch.sv
module irq_grp_latch #(
    parameter int NUM_GROUPS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_GROUPS-1:0] evt,
    input  logic [NUM_GROUPS-1:0] ack_clr,
    output logic [NUM_GROUPS-1:0] set_line,
    output logic [NUM_GROUPS-1:0] blocked
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic blk_q;

        assign set_line[g] = evt[g] && !blk_q;
        assign blocked[g]  = blk_q;

        always_ff @(posedge clk) begin
            if (rst)
                blk_q <= 1'b0;
            else if (ack_clr[g])
                blk_q <= 1'b0;
            else if (evt[g])
                blk_q <= 1'b1;
        end

        AST_GRP_HOLD: assert property (@(posedge clk) disable iff (rst)
            (blk_q && !ack_clr[g]) |=> blk_q); // R8
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int NUM_GROUPS  = 4,
    parameter int STACK_DEPTH = 4,
    parameter int DATA_W      = 16,
    localparam int VEC_W      = $clog2(NUM_LINES),
    localparam int FRAME_W    = NUM_LINES + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic [NUM_GROUPS-1:0] grp_evt,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  iret,
    output logic                  irq_req,
    output logic [VEC_W-1:0]      irq_vec
);

    // live state
    logic [NUM_LINES-1:0] pend_q, pend_n;
    logic [NUM_LINES-1:0] ier_q,  ier_n;
    logic                 gmask_q, gmask_n;
    logic                 pwe_q,   pwe_n;
    logic                 req_q;
    logic [VEC_W-1:0]     vec_q;

    // selection
    logic [NUM_LINES-1:0] elig;
    logic                 sel_found;
    logic [VEC_W-1:0]     sel_idx;
    ctx_act_e             act;

    // stack
    logic [FRAME_W-1:0]   top_frame;
    logic                 stk_empty;
    logic                 stk_ovf;

    // groups
    logic [NUM_GROUPS-1:0] grp_set;
    logic [NUM_GROUPS-1:0] grp_blk;
    logic [NUM_GROUPS-1:0] grp_ack;

    // register decode
    logic wr_pend, wr_enab, wr_ctrl, wr_gack;
    reg_sel_e sel;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_pend = reg_we && (sel == REG_PEND);
    assign wr_enab = reg_we && (sel == REG_ENAB);
    assign wr_ctrl = reg_we && (sel == REG_CTRL);
    assign wr_gack = reg_we && (sel == REG_GACK);
    assign grp_ack = wr_gack ? reg_wdata[NUM_GROUPS-1:0] : '0;

    assign elig = pend_q & ier_q;

    irq_prio_sel #(
        .NUM_LINES (NUM_LINES)
    ) i_prio (
        .elig  (elig),
        .found (sel_found),
        .idx   (sel_idx)
    );

    assign act = pick_action(sel_found && !gmask_q, iret, stk_empty);

    irq_ctx_stack #(
        .FRAME_W (FRAME_W),
        .DEPTH   (STACK_DEPTH)
    ) i_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (act == ACT_ENTER),
        .push_frame ({ier_q, gmask_q}),
        .pop        (act == ACT_RETURN),
        .top_frame  (top_frame),
        .empty      (stk_empty),
        .overflow   (stk_ovf)
    );

    irq_grp_latch #(
        .NUM_GROUPS (NUM_GROUPS)
    ) i_grp (
        .clk      (clk),
        .rst      (rst),
        .evt      (grp_evt),
        .ack_clr  (grp_ack),
        .set_line (grp_set),
        .blocked  (grp_blk)
    );

    // next-state: return beats entry beats software write
    always_comb begin
        pend_n  = pend_q;
        ier_n   = ier_q;
        gmask_n = gmask_q;
        pwe_n   = pwe_q;

        if (act == ACT_ENTER)
            pend_n[sel_idx] = 1'b0;
        pend_n = pend_n | irq_in;
        for (int g = 0; g < NUM_GROUPS; g++)
            pend_n[g] = pend_n[g] | grp_set[g];
        if (wr_pend)
            pend_n = pend_n | reg_wdata[NUM_LINES-1:0];

        unique case (act)
            ACT_RETURN: begin
                ier_n   = top_frame[FRAME_W-1:1];
                gmask_n = top_frame[0];
                if (wr_ctrl) pwe_n = reg_wdata[CTRL_PWE];
            end
            ACT_ENTER: begin
                ier_n[sel_idx] = 1'b0;
                gmask_n        = 1'b1;
                pwe_n          = 1'b0;
            end
            default: begin
                if (wr_enab) ier_n = reg_wdata[NUM_LINES-1:0];
                if (wr_ctrl) begin
                    gmask_n = reg_wdata[CTRL_GMASK];
                    pwe_n   = reg_wdata[CTRL_PWE];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            ier_q   <= '0;
            gmask_q <= 1'b1;
            pwe_q   <= 1'b0;
            req_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            pend_q  <= pend_n;
            ier_q   <= ier_n;
            gmask_q <= gmask_n;
            pwe_q   <= pwe_n;
            req_q   <= (act == ACT_ENTER);
            if (act == ACT_ENTER)
                vec_q <= sel_idx;
        end
    end

    assign irq_req = req_q;
    assign irq_vec = vec_q;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            REG_PEND: reg_rdata[NUM_LINES-1:0] = pend_q;
            REG_ENAB: reg_rdata[NUM_LINES-1:0] = ier_q;
            REG_CTRL: begin
                reg_rdata[CTRL_GMASK] = gmask_q;
                reg_rdata[CTRL_PWE]   = pwe_q;
                reg_rdata[CTRL_OVF]   = stk_ovf;
            end
            default:  reg_rdata[NUM_GROUPS-1:0] = grp_blk;
        endcase
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> !irq_req); // R2

    AST_ENTRY_MASKED: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (gmask_q && !pwe_q)); // R4

    AST_ENTRY_IER_CLR: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> !ier_q[irq_vec]); // R4

    AST_RET_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        iret |=> !irq_req); // R7

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (gmask_q && !iret && !wr_ctrl) |=> !irq_req); // R6

endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;

    localparam int N  = 8;
    localparam int G  = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic [G-1:0]  grp_evt = '0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          iret = 1'b0;
    logic          irq_req;
    logic [2:0]    irq_vec;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    bit done = 0;
    int unsigned exp_q[$];

    always #10 clk = ~clk;

    irq_entry_ctrl i_irq_entry_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .grp_evt   (grp_evt),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .iret      (iret),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && irq_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected request", int'(irq_vec), -1);
            end else begin
                int unsigned e;
                e = exp_q.pop_front();
                chk(irq_vec == e[2:0], "R2 vector", int'(irq_vec), int'(e));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000 && !done) begin
            chk(1'b0, "watchdog", cyc_cnt, 20000);
            finish_run();
        end
    end

    task automatic expect_vec(input int unsigned v);
        exp_q.push_back(v);
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == DW'(exp), req, int'(reg_rdata), exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ret();
        @(negedge clk); iret = 1'b1;
        @(negedge clk); iret = 1'b0;
    endtask

    task automatic pulse_grp(input logic [G-1:0] v);
        @(negedge clk); grp_evt = v;
        @(negedge clk); grp_evt = '0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R11 reset state
        rd(2'd0, 'h00, "R1 pending");
        rd(2'd1, 'h00, "R1 enable");
        rd(2'd2, 'h01, "R1 control");
        rd(2'd3, 'h00, "R1 group");
        chk(irq_req == 1'b0, "R1 req", int'(irq_req), 0);

        // R2 priority, R3/R4 entry effects
        wr(2'd1, 'hFF);
        wr(2'd0, 'h2C);
        rd(2'd0, 'h2C, "R11 pending write sets");
        expect_vec(2);
        wr(2'd2, 'h02);
        cyc(1);
        rd(2'd0, 'h28, "R3 pending cleared");
        rd(2'd1, 'hFB, "R4 enable bit cleared");
        rd(2'd2, 'h01, "R4 mask set, write-enable cleared");
        cyc(3);
        chk(irq_req == 1'b0, "R6 masked no take", int'(irq_req), 0);

        // R6 nesting via handler rewrite
        wr(2'd1, 'hF0);
        expect_vec(5);
        wr(2'd2, 'h00);
        cyc(1);
        rd(2'd1, 'hD0, "R4 nested enable");
        wr(2'd0, 'h10);

        // R7 back-to-back returns with eligible line in between
        expect_vec(3);
        @(negedge clk); iret = 1'b1;
        @(negedge clk);
        @(negedge clk); iret = 1'b0;
        chk(irq_req == 1'b0, "R7 no take on return", int'(irq_req), 0);
        rd(2'd1, 'hFF, "R5 enable restored");
        rd(2'd2, 'h00, "R5 mask restored");
        cyc(1);
        rd(2'd1, 'hF7, "R4 enable after line 3");

        expect_vec(4);
        ret();
        cyc(1);
        ret();
        cyc(1);
        // R10 empty return ignored
        wr(2'd1, 'h0F);
        wr(2'd2, 'h01);
        ret();
        rd(2'd1, 'h0F, "R10 enable unchanged");
        rd(2'd2, 'h01, "R10 control unchanged");

        // R9 overflow
        wr(2'd1, 'hFF);
        wr(2'd0, 'h1F);
        for (int k = 0; k < 5; k++) begin
            expect_vec(k);
            wr(2'd2, 'h00);
            cyc(1);
        end
        rd(2'd2, 'h05, "R9 overflow flag");
        ret();
        rd(2'd1, 'hF8, "R9 dropped frame");
        ret(); ret(); ret();
        rd(2'd1, 'hFF, "R9 outer frame");
        ret();
        rd(2'd1, 'hFF, "R10 enable after extra return");
        rd(2'd2, 'h04, "R9 overflow sticky");

        // R8 group latch
        wr(2'd1, 'h00);
        wr(2'd2, 'h01);
        pulse_grp(4'b0010);
        rd(2'd0, 'h02, "R8 group sets line");
        rd(2'd3, 'h02, "R8 group blocked");
        expect_vec(1);
        wr(2'd1, 'h02);
        wr(2'd2, 'h00);
        cyc(1);
        rd(2'd3, 'h02, "R8 entry keeps block");
        ret();
        pulse_grp(4'b0010);
        rd(2'd0, 'h00, "R8 blocked event ignored");
        wr(2'd3, 'h02);
        rd(2'd3, 'h00, "R8 acknowledge unblocks");
        expect_vec(1);
        pulse_grp(4'b0010);
        cyc(1);
        ret();
        cyc(1);

        // R12 event in the entry cycle
        wr(2'd1, 'h40);
        expect_vec(6);
        @(negedge clk); irq_in = 8'h40;
        @(negedge clk);
        @(negedge clk); irq_in = 8'h00;
        rd(2'd0, 'h40, "R12 line stays pending");
        rd(2'd1, 'h00, "R4 enable after line 6");
        expect_vec(6);
        ret();
        cyc(2);

        chk(exp_q.size() == 0, "R2 missing requests", exp_q.size(), 0);
        finish_run();
    end

endmodule